// File: doc/BRIEF.md
# Alarm Interrupt and Square-Wave Controller

This block holds the two special-purpose registers of a real-time clock: a control byte and a status byte. Together they decide how alarm events and a divided square wave reach two active-low output pins. Software reads and writes the registers through a byte-wide port. The register at offset Eh is the control byte and the one at Fh is the status byte. Two alarm comparators outside the block deliver one-cycle match pulses. The oscillator reports whether it is running. A 32.768 kHz level, already synchronous to the system clock, feeds the square-wave divider.

Each alarm pulse sets a sticky flag, and only a software write of 0 clears it. A routing bit picks what the second pin carries. In one setting it carries a square wave at one of four rates and both alarms share the first pin. In the other setting it carries the alarm 2 interrupt. An oscillator-stop flag records any period in which the oscillator was not running.

Top module: `alarm_pin_router`

## Requirements
- R1: Control register at offset Eh. Bit 7 stops the oscillator when 1, and `oscEnable` is its inverse. Bits 4:3 select the rate. Bit 2 is the routing bit. Bit 1 enables alarm 2 and bit 0 enables alarm 1. Bits 6:5 always read 0. A write takes effect at the next clock edge.
- R2: After reset the control register reads 18h, the status register reads 80h, `oscEnable` is 1 and `intAN` is 1.
- R3: Status register at offset Fh. Bit 7 is the oscillator-stop flag, bit 1 is the alarm 2 flag and bit 0 is the alarm 1 flag. Bits 6:2 read 0. Any offset other than Eh and Fh reads 00h.
- R4: With the routing bit at 0, `sqwIntBN` is a 50% square wave chosen by the rate field:
  - 11: the 32.768 kHz level, delayed by one register.
  - 10: the level divided by 4.
  - 01: the level divided by 8.
  - 00: the level divided by 2^SLOW_DIV_LOG2 (1 Hz at the default).
  - The dividers count rising edges of the level.
- R5: With the routing bit at 1, `sqwIntBN` is low exactly while the alarm 2 flag and its enable are both 1. In this mode `intAN` responds only to alarm 1 and its enable.
- R6: With the routing bit at 0, `intAN` is low exactly while (alarm 1 flag and its enable) or (alarm 2 flag and its enable).
- R7: An alarm match pulse sets its flag at the next clock edge. The flag then stays set without further pulses.
- R8: Writing 0 to bit 0 or bit 1 of the status register clears that flag. Writing 1 leaves it unchanged.
- R9: If a match pulse and a clearing write hit the same flag in one cycle, the flag ends up set.
- R10: The oscillator-stop flag is set at the edge after `oscRunning` is low or control bit 7 is 1. Writing 0 to status bit 7 clears it only when neither condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register offset for reads and writes |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| alarm1Hit | input | 1 | One-cycle alarm 1 match pulse |
| alarm2Hit | input | 1 | One-cycle alarm 2 match pulse |
| oscRunning | input | 1 | High while the oscillator runs |
| slowClkLvl | input | 1 | 32.768 kHz level, synchronous to `clk` |
| intAN | output | 1 | Active-low interrupt A |
| sqwIntBN | output | 1 | Square wave or active-low interrupt B |
| oscEnable | output | 1 | Oscillator enable (inverse of control bit 7) |

## Verification
Two things can land on the same flag in the same cycle. One is a hardware set (an alarm pulse, or a stopped or disabled oscillator). The other is a software write of 0 to that flag's status bit. The bench drives an alarm pulse together with a status write of 00h, and pulls `oscRunning` low on the same cycle as an oscillator-stop clear. It then reads the status byte back one edge later and expects the flag still set. A behavioural model runs alongside and compares read data and both pins every cycle, so the sticky result is also checked against the model's own ordering of set over clear.

// File: rtl/alarm_pin_pkg.sv
package alarm_pin_pkg;

  // register offsets; software decodes these
  localparam int CTRL_OFS = 14;
  localparam int STAT_OFS = 15;

  // square-wave rate field, bits 4:3 of the control byte
  typedef enum logic [1:0] {
    RATE_SLOW = 2'b00,
    RATE_DIV8 = 2'b01,
    RATE_DIV4 = 2'b10,
    RATE_PASS = 2'b11
  } rate_e;

  typedef struct packed {
    logic  oscStop;   // 1 stops the oscillator
    rate_e rate;
    logic  routeIrq;  // 1: pin B carries alarm 2 interrupt
    logic  a2En;
    logic  a1En;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{oscStop: 1'b0, rate: RATE_PASS,
                                 routeIrq: 1'b0, a2En: 1'b0, a1En: 1'b0};

  // strobes from register decode to the datapath
  typedef struct packed {
    logic       wrCtrl;
    ctrl_t      ctrlWord;
    logic       clrOsf;
    logic [1:0] clrAlarm;
    logic       rdCtrl;
    logic       rdStat;
  } regStb_t;

endpackage

// File: rtl/alarm_pin_ctrl.sv
module alarm_pin_ctrl
  import alarm_pin_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output regStb_t           stb
);

  logic hitCtrl;
  logic hitStat;
  logic unusedRsv;

  assign hitCtrl   = (regAddr == ADDR_W'(CTRL_OFS));
  assign hitStat   = (regAddr == ADDR_W'(STAT_OFS));
  assign unusedRsv = ^regWrData[6:5];

  always_comb begin
    stb             = '0;
    stb.rdCtrl      = hitCtrl;
    stb.rdStat      = hitStat;
    stb.wrCtrl      = regWrEn && hitCtrl;
    stb.ctrlWord    = ctrl_t'({regWrData[7], regWrData[4:0]});
    stb.clrOsf      = regWrEn && hitStat && !regWrData[7];
    stb.clrAlarm[0] = regWrEn && hitStat && !regWrData[0];
    stb.clrAlarm[1] = regWrEn && hitStat && !regWrData[1];
  end

endmodule

// File: rtl/alarm_pin_dp.sv
module alarm_pin_dp
  import alarm_pin_pkg::*;
#(
  parameter int SLOW_DIV_LOG2 = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  regStb_t    stb,
  input  logic       alarm1Hit,
  input  logic       alarm2Hit,
  input  logic       oscRunning,
  input  logic       slowClkLvl,
  output ctrl_t      ctrlQ,
  output logic       flagOsf,
  output logic       flagA2,
  output logic       flagA1,
  output logic [7:0] rdData,
  output logic       intAN,
  output logic       sqwIntBN,
  output logic       oscEnable
);

  localparam int CNT_W     = SLOW_DIV_LOG2;
  localparam int N_ALARMS  = 2;

  logic [N_ALARMS-1:0] alarmHit;
  logic [N_ALARMS-1:0] alarmFlag;
  logic                oscHalted;
  logic                slowQ;
  logic                slowRise;
  logic [CNT_W-1:0]    divCnt;
  logic [3:0]          rateTap;
  logic                sqwLevel;
  logic                reqA;
  logic                reqB;

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ctrlQ <= CTRL_RST;
    else if (stb.wrCtrl) ctrlQ <= stb.ctrlWord;
  end

  // sticky alarm flags, set has priority over clear
  assign alarmHit = {alarm2Hit, alarm1Hit};

  for (genvar g = 0; g < N_ALARMS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  alarmFlag[g] <= 1'b0;
      else if (alarmHit[g])       alarmFlag[g] <= 1'b1;
      else if (stb.clrAlarm[g])   alarmFlag[g] <= 1'b0;
    end
  end

  assign flagA1 = alarmFlag[0];
  assign flagA2 = alarmFlag[1];

  // oscillator-stop flag
  assign oscHalted = !oscRunning || ctrlQ.oscStop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           flagOsf <= 1'b1;
    else if (oscHalted)  flagOsf <= 1'b1;
    else if (stb.clrOsf) flagOsf <= 1'b0;
  end

  // square-wave divider on rising edges of the slow level
  assign slowRise = slowClkLvl && !slowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slowQ  <= 1'b0;
      divCnt <= '0;
    end else begin
      slowQ <= slowClkLvl;
      if (slowRise) divCnt <= divCnt + 1'b1;
    end
  end

  // index matches rate_e encoding
  assign rateTap  = {slowQ, divCnt[1], divCnt[2], divCnt[CNT_W-1]};
  assign sqwLevel = rateTap[ctrlQ.rate];

  // pin routing
  assign reqA = (flagA1 && ctrlQ.a1En) || (flagA2 && ctrlQ.a2En && !ctrlQ.routeIrq);
  assign reqB = flagA2 && ctrlQ.a2En;

  assign intAN     = !reqA;
  assign sqwIntBN  = ctrlQ.routeIrq ? !reqB : sqwLevel;
  assign oscEnable = !ctrlQ.oscStop;

  // read mux
  always_comb begin
    rdData = 8'h00;
    if (stb.rdCtrl)
      rdData = {ctrlQ.oscStop, 2'b00, ctrlQ.rate, ctrlQ.routeIrq, ctrlQ.a2En, ctrlQ.a1En};
    else if (stb.rdStat)
      rdData = {flagOsf, 5'b00000, flagA2, flagA1};
  end

endmodule

// File: rtl/alarm_pin_router.sv
module alarm_pin_router
  import alarm_pin_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int SLOW_DIV_LOG2 = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              alarm1Hit,
  input  logic              alarm2Hit,
  input  logic              oscRunning,
  input  logic              slowClkLvl,
  output logic              intAN,
  output logic              sqwIntBN,
  output logic              oscEnable
);

  regStb_t stb;
  ctrl_t   ctrlQ;
  logic    flagOsf;
  logic    flagA2;
  logic    flagA1;

  alarm_pin_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .stb      (stb)
  );

  alarm_pin_dp #(.SLOW_DIV_LOG2(SLOW_DIV_LOG2)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .alarm1Hit (alarm1Hit),
    .alarm2Hit (alarm2Hit),
    .oscRunning(oscRunning),
    .slowClkLvl(slowClkLvl),
    .ctrlQ     (ctrlQ),
    .flagOsf   (flagOsf),
    .flagA2    (flagA2),
    .flagA1    (flagA1),
    .rdData    (regRdData),
    .intAN     (intAN),
    .sqwIntBN  (sqwIntBN),
    .oscEnable (oscEnable)
  );

endmodule

// File: rtl/alarm_pin_router_chk.sv
module alarm_pin_router_chk
  import alarm_pin_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWrData,
  input logic              alarm1Hit,
  input logic              alarm2Hit,
  input logic              oscRunning,
  input logic              intAN,
  input logic              sqwIntBN,
  input ctrl_t             ctrlQ,
  input logic              flagOsf,
  input logic              flagA2,
  input logic              flagA1
);

  logic statWr;
  assign statWr = regWrEn && (regAddr == ADDR_W'(STAT_OFS));

  assert_a1_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    alarm1Hit |=> flagA1);

  assert_a2_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    alarm2Hit |=> flagA2);

  assert_a1_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flagA1 && !(statWr && !regWrData[0])) |=> flagA1);

  assert_a1_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !regWrData[0] && !alarm1Hit) |=> !flagA1);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (alarm2Hit && statWr && !regWrData[1]) |=> flagA2);

  assert_osf_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!oscRunning || ctrlQ.oscStop) |=> flagOsf);

  assert_a2_on_a_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ.routeIrq && flagA2 && ctrlQ.a2En) |-> !intAN);

  assert_a_only_a1_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.routeIrq && !(flagA1 && ctrlQ.a1En)) |-> intAN);

  assert_b_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.routeIrq && !flagA2) |-> sqwIntBN);

endmodule

bind alarm_pin_router alarm_pin_router_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/alarm_pin_router_bench.sv
`timescale 1ns/1ps
module alarm_pin_router_bench;

  localparam int ADDR_W = 4;
  localparam int L      = 6;
  localparam int WDOG   = 100000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [7:0]       regWrData = 8'h00;
  logic [7:0]       regRdData;
  logic             alarm1Hit = 1'b0;
  logic             alarm2Hit = 1'b0;
  logic             oscRunning = 1'b1;
  logic             slowClkLvl = 1'b0;
  logic             intAN;
  logic             sqwIntBN;
  logic             oscEnable;

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alarm_pin_router #(.ADDR_W(ADDR_W), .SLOW_DIV_LOG2(L)) u_alarm_pin_router (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .alarm1Hit(alarm1Hit),
    .alarm2Hit(alarm2Hit), .oscRunning(oscRunning), .slowClkLvl(slowClkLvl),
    .intAN(intAN), .sqwIntBN(sqwIntBN), .oscEnable(oscEnable)
  );

  // reference model state
  logic [7:0] mCtrl = 8'h18;
  logic       mOsf = 1'b1, mA2 = 1'b0, mA1 = 1'b0, mSlowPrev = 1'b0;
  int         mCnt = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 8'h18; mOsf = 1'b1; mA2 = 1'b0; mA1 = 1'b0;
      mSlowPrev = 1'b0; mCnt = 0;
    end else begin
      if (slowClkLvl && !mSlowPrev) mCnt = (mCnt + 1) % (1 << L);
      mSlowPrev = slowClkLvl;
      if (!oscRunning || mCtrl[7]) mOsf = 1'b1;
      else if (regWrEn && regAddr == 4'hF && !regWrData[7]) mOsf = 1'b0;
      if (alarm1Hit) mA1 = 1'b1;
      else if (regWrEn && regAddr == 4'hF && !regWrData[0]) mA1 = 1'b0;
      if (alarm2Hit) mA2 = 1'b1;
      else if (regWrEn && regAddr == 4'hF && !regWrData[1]) mA2 = 1'b0;
      if (regWrEn && regAddr == 4'hE) mCtrl = regWrData & 8'h9F;
    end
    started = 1;
  end

  function automatic logic [7:0] expRd();
    if (regAddr == 4'hE) return mCtrl;
    if (regAddr == 4'hF) return {mOsf, 5'b0, mA2, mA1};
    return 8'h00;
  endfunction

  function automatic logic expA();
    return !((mA1 && mCtrl[0]) || (mA2 && mCtrl[1] && !mCtrl[2]));
  endfunction

  function automatic logic expB();
    if (mCtrl[2]) return !(mA2 && mCtrl[1]);
    case (mCtrl[4:3])
      2'b11:   return mSlowPrev;
      2'b10:   return 1'((mCnt >> 1) & 1);
      2'b01:   return 1'((mCnt >> 2) & 1);
      default: return 1'((mCnt >> (L - 1)) & 1);
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #5;
    if (started && rstN && !done) begin
      check("R3 read data", regRdData, expRd());
      check("R6 intAN", intAN, expA());
      check("R4 sqwIntBN", sqwIntBN, expB());
      check("R1 oscEnable", oscEnable, !mCtrl[7]);
    end
  end

  // slow level: toggles every 3 system cycles
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      slowClkLvl = ~slowClkLvl;
    end
  end

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    @(posedge clk); #5;
    check(tag, regRdData, exp);
  endtask

  task automatic pulse(input bit which2);
    @(negedge clk);
    if (which2) alarm2Hit = 1'b1; else alarm1Hit = 1'b1;
    @(negedge clk);
    alarm1Hit = 1'b0; alarm2Hit = 1'b0;
  endtask

  task automatic countToggles(input int cycles, input int exp, input string tag);
    int n = 0;
    logic prev;
    @(negedge clk);
    prev = sqwIntBN;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sqwIntBN != prev) n++;
      prev = sqwIntBN;
    end
    checks++;
    if (n < exp - 1 || n > exp + 1) begin
      failures++;
      $display("FAIL %s toggles actual=%0d expected=%0d", tag, n, exp);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R2 reset state
    readCheck(4'hE, 8'h18, "R2 ctrl reset");
    readCheck(4'hF, 8'h80, "R2 status reset");
    check("R2 oscEnable", oscEnable, 1);
    check("R2 intAN", intAN, 1);
    // R3 unmapped offset
    readCheck(4'h3, 8'h00, "R3 unmapped");
    // R10 clear, then clear ignored while stopped
    writeReg(4'hF, 8'h00);
    readCheck(4'hF, 8'h00, "R10 osf clear");
    @(negedge clk);
    oscRunning = 1'b0; regWrEn = 1'b1; regAddr = 4'hF; regWrData = 8'h00;
    @(negedge clk);
    oscRunning = 1'b1; regWrEn = 1'b0;
    readCheck(4'hF, 8'h80, "R10 osf set wins");
    writeReg(4'hF, 8'h00);
    // R1 control write, reserved bits, oscillator stop
    writeReg(4'hE, 8'hFF);
    check("R1 oscEnable low", oscEnable, 0);
    readCheck(4'hE, 8'h9F, "R1 ctrl readback");
    readCheck(4'hF, 8'h80, "R10 osf from stop bit");
    writeReg(4'hE, 8'h18);
    writeReg(4'hF, 8'h00);
    readCheck(4'hF, 8'h00, "R10 osf cleared");
    // R7 set and hold, R8 clear rules
    pulse(0);
    readCheck(4'hF, 8'h01, "R7 a1 set");
    pulse(1);
    readCheck(4'hF, 8'h03, "R7 a2 set, a1 held");
    writeReg(4'hF, 8'hFF);
    readCheck(4'hF, 8'h03, "R8 write ones");
    writeReg(4'hF, 8'h02);
    readCheck(4'hF, 8'h02, "R8 clear a1 only");
    writeReg(4'hF, 8'h00);
    readCheck(4'hF, 8'h00, "R8 clear a2");
    // R9 set and clear in the same cycle
    @(negedge clk);
    alarm1Hit = 1'b1; alarm2Hit = 1'b1;
    regWrEn = 1'b1; regAddr = 4'hF; regWrData = 8'h00;
    @(negedge clk);
    alarm1Hit = 1'b0; alarm2Hit = 1'b0; regWrEn = 1'b0;
    readCheck(4'hF, 8'h03, "R9 set wins");
    // R6 shared pin A
    writeReg(4'hE, 8'h1A);
    #1 check("R6 a2 on pin A", intAN, 0);
    writeReg(4'hE, 8'h18);
    #1 check("R6 no enables", intAN, 1);
    writeReg(4'hE, 8'h19);
    #1 check("R6 a1 on pin A", intAN, 0);
    // R5 split routing
    writeReg(4'hE, 8'h1F);
    #1 check("R5 pin A a1", intAN, 0);
    check("R5 pin B a2", sqwIntBN, 0);
    writeReg(4'hF, 8'h02);
    #1 check("R5 pin A free of a2", intAN, 1);
    check("R5 pin B still low", sqwIntBN, 0);
    writeReg(4'hE, 8'h1D);
    #1 check("R5 pin B disabled", sqwIntBN, 1);
    writeReg(4'hF, 8'h00);
    // R4 rates
    writeReg(4'hE, 8'h18);
    countToggles(768, 256, "R4 pass");
    writeReg(4'hE, 8'h10);
    countToggles(768, 64, "R4 div4");
    writeReg(4'hE, 8'h08);
    countToggles(768, 32, "R4 div8");
    writeReg(4'hE, 8'h00);
    countToggles(768, 4, "R4 slow");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule